// File: doc/BRIEF.md
# TDM Serial Bit Timing Unit

This unit produces the timing for a TDM serial port that carries 125 us frames. It receives the master clock, the 8 kHz frame pulse and a few configuration bits. From these it produces the per-bit strobes and the bit and channel positions that a serial-to-parallel and parallel-to-serial data path needs on its input side and its output side.

The unit finds the backplane format by itself from the first valid frame pulse it receives after reset. An active-low pulse selects the format that transmits on the falling clock edge and samples on the rising edge. An active-high pulse selects the opposite pair of edges. The unit reports the chosen edges to the data path through two edge-select outputs. After a format is found, the unit locks to it and restarts both counters at the trailing edge of every later pulse of the same polarity.

Each side (input and output) has its own rate: 2.048, 4.096 or 8.192 Mb/s. A bit lasts 1, 2 or 4 master clocks. When the two rates are equal, a clock-mode bit chooses between one clock per bit and two clocks per bit. When the rates differ, the faster side runs at one clock per bit, the slower side stretches its bits by the rate ratio, and the clock-mode bit is ignored. On each side, the sample strobe falls three quarters of the way into the bit cell.

Top module: `tdm_bit_timing`

## Requirements
- R1: After reset `fmt_valid_o`=0 and `fmt_gci_o`=0. A complete pulse sets `fmt_valid_o`. A complete pulse is a departure of `fp_i` from its previous level that lasts 1 to PULSE_MAX (default 4) clock samples and then returns. It counts only if a level change has already been seen since reset. `fmt_gci_o` takes the pulse level (0 = active-low, 1 = active-high). While `fmt_valid_o`=0, all strobes are 0 and all indices are 0.
- R2: A departure longer than PULSE_MAX samples is not a pulse and leaves `fmt_valid_o` at 0.
- R3: Once `fmt_valid_o`=1, both `fmt_valid_o` and `fmt_gci_o` hold until reset. A pulse of the opposite polarity changes nothing.
- R4: A frame boundary is the clock edge at which `fp_i` leaves the active level. This includes the edge at which the format is found. In the cycle after a frame boundary, both bit indices and both channel indices are 0 and both boundary strobes are 1.
- R5: With equal rates and `clk_mode_i`=0, each bit lasts 2 clocks. The boundary strobe is on phase 0 and the sample strobe is on phase 1, never in the same cycle.
- R6: With equal rates and `clk_mode_i`=1, each bit lasts 1 clock. Boundary, sample and transmit strobes are high on every cycle.
- R7: With unequal rates, `clk_mode_i` has no effect. The faster side uses 1 clock per bit. The slower side uses 2 clocks per bit (rate ratio 2) or 4 clocks per bit (ratio 4), with its sample strobe on phase 3 of 4.
- R8: Rate code 0, 1 and 2 give 256, 512 and 1024 bits per frame. Code 3 behaves as code 2. Without a frame pulse, the bit count wraps to 0 after the last bit.
- R9: `tx_fall_o`=1 and `smp_fall_o`=0 when `fmt_gci_o`=0. The two values swap when `fmt_gci_o`=1.
- R10: The channel output is the frame bit index divided by 8. The bit output is the index modulo 8, so bit 0 is the first bit of each channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_i | input | 1 | Frame pulse, sampled on the rising edge |
| clk_mode_i | input | 1 | 0: two clocks per bit, 1: one clock per bit (used only when rates are equal) |
| in_rate_i | input | 2 | Input-side rate code (0/1/2/3) |
| out_rate_i | input | 2 | Output-side rate code (0/1/2/3) |
| fmt_valid_o | output | 1 | Frame format has been found |
| fmt_gci_o | output | 1 | Found format is active-high |
| tx_fall_o | output | 1 | Transmit on falling edge |
| smp_fall_o | output | 1 | Sample on falling edge |
| in_bnd_o | output | 1 | Input-side bit boundary strobe |
| in_smp_o | output | 1 | Input-side sample strobe |
| in_chan_o | output | 7 | Input-side channel index |
| in_bit_o | output | 3 | Input-side bit within channel |
| out_tx_o | output | 1 | Output-side transmit (bit boundary) strobe |
| out_smp_o | output | 1 | Output-side sample-point strobe |
| out_chan_o | output | 7 | Output-side channel index |
| out_bit_o | output | 3 | Output-side bit within channel |

## Verification
The bench sends a low departure that is too long before the first real pulse. A detector that does not limit pulse width would lock on that departure and start counting early. After locking, the bench applies a short pulse of the opposite polarity. A unit that relearns its format would flip its edge selects.

The bench runs each configuration longer than one frame without a pulse, to catch counters that run past 256, 512 or 1024 bits. It also uses code 3 to catch a missing alias to code 2. Windows with unequal rates are repeated with both clock-mode values. A design that let the clock-mode bit act there would change the strobe counts on the slow side, and a wrong three-quarter phase would show up as a misplaced sample strobe.

// File: rtl/tdm_bt_pkg.sv
`timescale 1ns/1ps
package tdm_bt_pkg;

  typedef enum logic [1:0] {
    RATE_2M048 = 2'd0,
    RATE_4M096 = 2'd1,
    RATE_8M192 = 2'd2,
    RATE_ALIAS = 2'd3
  } rate_e;

  // Per-side timing: normalised rate code and log2 of clocks per bit.
  typedef struct packed {
    logic [1:0] rate;
    logic [1:0] cpb_log;
  } side_cfg_t;

  localparam int NUM_SIDES   = 2;
  localparam int SIDE_IN     = 0;
  localparam int SIDE_OUT    = 1;
  localparam int BIT_IN_CH_W = 3;

endpackage

// File: rtl/tdm_bt_rate_map.sv
`timescale 1ns/1ps
module tdm_bt_rate_map
  import tdm_bt_pkg::*;
(
  input  logic       clk_mode_i,
  input  logic [1:0] in_rate_i,
  input  logic [1:0] out_rate_i,
  output side_cfg_t  in_cfg_o,
  output side_cfg_t  out_cfg_o
);

  logic [1:0] in_n, out_n, fast_n;
  logic       same_rate;

  function automatic logic [1:0] norm_rate(input logic [1:0] r);
    return (r == 2'(RATE_ALIAS)) ? 2'(RATE_8M192) : r;
  endfunction

  always_comb begin
    in_n      = norm_rate(in_rate_i);
    out_n     = norm_rate(out_rate_i);
    same_rate = (in_n == out_n);
    fast_n    = (in_n > out_n) ? in_n : out_n;

    in_cfg_o.rate  = in_n;
    out_cfg_o.rate = out_n;
    if (same_rate) begin
      in_cfg_o.cpb_log  = clk_mode_i ? 2'd0 : 2'd1;
      out_cfg_o.cpb_log = clk_mode_i ? 2'd0 : 2'd1;
    end else begin
      in_cfg_o.cpb_log  = fast_n - in_n;
      out_cfg_o.cpb_log = fast_n - out_n;
    end
  end

endmodule

// File: rtl/tdm_bt_fp_detect.sv
`timescale 1ns/1ps
module tdm_bt_fp_detect #(
  parameter int PULSE_MAX = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fp_i,
  output logic valid_o,
  output logic gci_o,
  output logic frame_start_o
);

  localparam int RUN_SAT = PULSE_MAX + 1;
  localparam int RUN_W   = $clog2(RUN_SAT + 1);

  logic             fp_q, primed_q, seen_q, valid_q, gci_q;
  logic             fp_d, primed_d, seen_d, valid_d, gci_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             changed, pulse_ok, frame_start;

  always_comb begin
    changed     = primed_q && (fp_i != fp_q);
    pulse_ok    = seen_q && (run_q <= RUN_W'(PULSE_MAX));
    frame_start = changed && (valid_q ? (fp_q == gci_q) : pulse_ok);

    fp_d     = fp_i;
    primed_d = 1'b1;
    seen_d   = seen_q | changed;
    if (changed)
      run_d = RUN_W'(1);
    else if (run_q == RUN_W'(RUN_SAT))
      run_d = run_q;
    else
      run_d = run_q + 1'b1;
    valid_d = valid_q | frame_start;
    gci_d   = (!valid_q && frame_start) ? fp_q : gci_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_q     <= 1'b0;
      primed_q <= 1'b0;
      seen_q   <= 1'b0;
      run_q    <= '0;
      valid_q  <= 1'b0;
      gci_q    <= 1'b0;
    end else begin
      fp_q     <= fp_d;
      primed_q <= primed_d;
      seen_q   <= seen_d;
      run_q    <= run_d;
      valid_q  <= valid_d;
      gci_q    <= gci_d;
    end
  end

  assign valid_o       = valid_q;
  assign gci_o         = gci_q;
  assign frame_start_o = frame_start;

endmodule

// File: rtl/tdm_bt_side_ctr.sv
`timescale 1ns/1ps
module tdm_bt_side_ctr
  import tdm_bt_pkg::*;
#(
  parameter int BASE_BITS = 256,
  parameter int IDX_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  side_cfg_t        cfg_i,
  output logic             bnd_o,
  output logic             smp_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam int             PH_W   = 2;
  localparam logic [IDX_W:0] BASE_V = (IDX_W+1)'(BASE_BITS);

  logic [PH_W-1:0]  ph_q, ph_d, ph_last, ph_smp;
  logic [IDX_W-1:0] idx_q, idx_d, idx_last;
  logic [IDX_W:0]   frame_len;
  logic             cnt_en;

  always_comb begin
    frame_len = BASE_V << cfg_i.rate;
    idx_last  = IDX_W'(frame_len - 1'b1);
    ph_last   = PH_W'((3'd1 << cfg_i.cpb_log) - 3'd1);
    ph_smp    = PH_W'((4'd3 << cfg_i.cpb_log) >> 2);
    cnt_en    = restart_i | run_i;

    ph_d  = ph_q;
    idx_d = idx_q;
    if (restart_i) begin
      ph_d  = '0;
      idx_d = '0;
    end else if (ph_q >= ph_last) begin
      ph_d  = '0;
      idx_d = (idx_q >= idx_last) ? '0 : idx_q + 1'b1;
    end else begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      idx_q <= '0;
    end else if (cnt_en) begin
      ph_q  <= ph_d;
      idx_q <= idx_d;
    end
  end

  assign bnd_o = run_i && (ph_q == '0);
  assign smp_o = run_i && (ph_q == ph_smp);
  assign idx_o = idx_q;

endmodule

// File: rtl/tdm_bit_timing.sv
`timescale 1ns/1ps
module tdm_bit_timing
  import tdm_bt_pkg::*;
#(
  parameter  int BASE_BITS = 256,
  parameter  int PULSE_MAX = 4,
  localparam int IDX_W     = $clog2(BASE_BITS) + 2,
  localparam int CH_W      = IDX_W - BIT_IN_CH_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fp_i,
  input  logic                   clk_mode_i,
  input  logic [1:0]             in_rate_i,
  input  logic [1:0]             out_rate_i,
  output logic                   fmt_valid_o,
  output logic                   fmt_gci_o,
  output logic                   tx_fall_o,
  output logic                   smp_fall_o,
  output logic                   in_bnd_o,
  output logic                   in_smp_o,
  output logic [CH_W-1:0]        in_chan_o,
  output logic [BIT_IN_CH_W-1:0] in_bit_o,
  output logic                   out_tx_o,
  output logic                   out_smp_o,
  output logic [CH_W-1:0]        out_chan_o,
  output logic [BIT_IN_CH_W-1:0] out_bit_o
);

  side_cfg_t        side_cfg [NUM_SIDES];
  logic             side_bnd [NUM_SIDES];
  logic             side_smp [NUM_SIDES];
  logic [IDX_W-1:0] side_idx [NUM_SIDES];
  logic             valid, gci, frame_start;

  tdm_bt_fp_detect #(.PULSE_MAX(PULSE_MAX)) u_detect (
    .clk           (clk),
    .rst_n         (rst_n),
    .fp_i          (fp_i),
    .valid_o       (valid),
    .gci_o         (gci),
    .frame_start_o (frame_start)
  );

  tdm_bt_rate_map u_rate_map (
    .clk_mode_i (clk_mode_i),
    .in_rate_i  (in_rate_i),
    .out_rate_i (out_rate_i),
    .in_cfg_o   (side_cfg[SIDE_IN]),
    .out_cfg_o  (side_cfg[SIDE_OUT])
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    tdm_bt_side_ctr #(.BASE_BITS(BASE_BITS), .IDX_W(IDX_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (valid),
      .restart_i (frame_start),
      .cfg_i     (side_cfg[s]),
      .bnd_o     (side_bnd[s]),
      .smp_o     (side_smp[s]),
      .idx_o     (side_idx[s])
    );
  end

  assign fmt_valid_o = valid;
  assign fmt_gci_o   = gci;
  assign tx_fall_o   = ~gci;
  assign smp_fall_o  = gci;

  assign in_bnd_o   = side_bnd[SIDE_IN];
  assign in_smp_o   = side_smp[SIDE_IN];
  assign in_chan_o  = side_idx[SIDE_IN][IDX_W-1:BIT_IN_CH_W];
  assign in_bit_o   = side_idx[SIDE_IN][BIT_IN_CH_W-1:0];
  assign out_tx_o   = side_bnd[SIDE_OUT];
  assign out_smp_o  = side_smp[SIDE_OUT];
  assign out_chan_o = side_idx[SIDE_OUT][IDX_W-1:BIT_IN_CH_W];
  assign out_bit_o  = side_idx[SIDE_OUT][BIT_IN_CH_W-1:0];

endmodule

// File: rtl/tdm_bit_timing_chk.sv
`timescale 1ns/1ps
module tdm_bit_timing_chk #(
  parameter int CH_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fp_i,
  input logic            clk_mode_i,
  input logic [1:0]      in_rate_i,
  input logic [1:0]      out_rate_i,
  input logic            fmt_valid_o,
  input logic            fmt_gci_o,
  input logic            tx_fall_o,
  input logic            smp_fall_o,
  input logic            in_bnd_o,
  input logic            in_smp_o,
  input logic [CH_W-1:0] in_chan_o,
  input logic [2:0]      in_bit_o,
  input logic            out_tx_o,
  input logic [CH_W-1:0] out_chan_o,
  input logic [2:0]      out_bit_o
);

  p_quiet_before_lock_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_valid_o |-> (!in_bnd_o && !in_smp_o && !out_tx_o &&
                      in_chan_o == '0 && out_chan_o == '0));

  p_format_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_valid_o |=> (fmt_valid_o && $stable(fmt_gci_o)));

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_valid_o && fp_i != $past(fp_i) && $past(fp_i) == fmt_gci_o) |=>
      (in_bnd_o && out_tx_o && in_chan_o == '0 && in_bit_o == '0 &&
       out_chan_o == '0 && out_bit_o == '0));

  p_split_phases_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_mode_i && in_rate_i == out_rate_i) |-> !(in_bnd_o && in_smp_o));

  p_every_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_valid_o && clk_mode_i && in_rate_i == out_rate_i) |=>
      (!(clk_mode_i && in_rate_i == out_rate_i) || (in_bnd_o && in_smp_o && out_tx_o)));

  p_edge_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fall_o != smp_fall_o);

endmodule

bind tdm_bit_timing tdm_bit_timing_chk #(.CH_W(CH_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fp_i        (fp_i),
  .clk_mode_i  (clk_mode_i),
  .in_rate_i   (in_rate_i),
  .out_rate_i  (out_rate_i),
  .fmt_valid_o (fmt_valid_o),
  .fmt_gci_o   (fmt_gci_o),
  .tx_fall_o   (tx_fall_o),
  .smp_fall_o  (smp_fall_o),
  .in_bnd_o    (in_bnd_o),
  .in_smp_o    (in_smp_o),
  .in_chan_o   (in_chan_o),
  .in_bit_o    (in_bit_o),
  .out_tx_o    (out_tx_o),
  .out_chan_o  (out_chan_o),
  .out_bit_o   (out_bit_o)
);

// File: tb/tdm_bit_timing_tb.sv
`timescale 1ns/1ps
module tdm_bit_timing_tb;

  localparam int BASE = 256;
  localparam int PMAX = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fp = 1'b1;
  logic       cm = 1'b0;
  logic [1:0] ir = 2'd0;
  logic [1:0] orr = 2'd0;

  logic       fmt_valid_o, fmt_gci_o, tx_fall_o, smp_fall_o;
  logic       in_bnd_o, in_smp_o, out_tx_o, out_smp_o;
  logic [6:0] in_chan_o, out_chan_o;
  logic [2:0] in_bit_o, out_bit_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  int m_fpq, m_primed, m_seen, m_run, m_valid, m_gci;
  int m_ph [2];
  int m_idx [2];

  always #2.5 clk = ~clk;

  tdm_bit_timing u_dut (
    .clk(clk), .rst_n(rst_n), .fp_i(fp), .clk_mode_i(cm),
    .in_rate_i(ir), .out_rate_i(orr),
    .fmt_valid_o(fmt_valid_o), .fmt_gci_o(fmt_gci_o),
    .tx_fall_o(tx_fall_o), .smp_fall_o(smp_fall_o),
    .in_bnd_o(in_bnd_o), .in_smp_o(in_smp_o),
    .in_chan_o(in_chan_o), .in_bit_o(in_bit_o),
    .out_tx_o(out_tx_o), .out_smp_o(out_smp_o),
    .out_chan_o(out_chan_o), .out_bit_o(out_bit_o)
  );

  function automatic int nrm(input int r);
    return (r == 3) ? 2 : r;
  endfunction

  function automatic int clocks_per_bit(input int side);
    int a, b;
    a = nrm(int'(ir));
    b = nrm(int'(orr));
    if (a == b) return cm ? 1 : 2;
    if (side == 0) return (a > b) ? 1 : (1 << (b - a));
    return (b > a) ? 1 : (1 << (a - b));
  endfunction

  function automatic int smp_phase(input int side);
    return (clocks_per_bit(side) * 3) / 4;
  endfunction

  function automatic int frame_bits(input int side);
    return BASE * (1 << nrm(int'(side == 0 ? ir : orr)));
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int eb, es;
    chk("R1", "fmt_valid", int'(fmt_valid_o), m_valid);
    chk("R1", "fmt_gci", int'(fmt_gci_o), m_gci);
    chk("R9", "tx_fall", int'(tx_fall_o), m_gci ? 0 : 1);
    chk("R9", "smp_fall", int'(smp_fall_o), m_gci);
    for (int s = 0; s < 2; s++) begin
      eb = (m_valid != 0 && m_ph[s] == 0) ? 1 : 0;
      es = (m_valid != 0 && m_ph[s] == smp_phase(s)) ? 1 : 0;
      chk("R5 R6 R7", s == 0 ? "in_bnd" : "out_tx", int'(s == 0 ? in_bnd_o : out_tx_o), eb);
      chk("R5 R6 R7", s == 0 ? "in_smp" : "out_smp", int'(s == 0 ? in_smp_o : out_smp_o), es);
      chk("R8 R10", s == 0 ? "in_chan" : "out_chan", int'(s == 0 ? in_chan_o : out_chan_o), m_idx[s] / 8);
      chk("R10", s == 0 ? "in_bit" : "out_bit", int'(s == 0 ? in_bit_o : out_bit_o), m_idx[s] % 8);
    end
  endtask

  // advance model across the coming rising edge
  task automatic mstep();
    int changed, fs;
    if (!rst_n) begin
      m_fpq = 0; m_primed = 0; m_seen = 0; m_run = 0; m_valid = 0; m_gci = 0;
      for (int s = 0; s < 2; s++) begin m_ph[s] = 0; m_idx[s] = 0; end
      return;
    end
    changed = (m_primed != 0 && int'(fp) != m_fpq) ? 1 : 0;
    if (m_valid != 0) fs = (changed != 0 && m_fpq == m_gci) ? 1 : 0;
    else fs = (changed != 0 && m_seen != 0 && m_run <= PMAX) ? 1 : 0;
    for (int s = 0; s < 2; s++) begin
      if (fs != 0) begin
        m_ph[s] = 0; m_idx[s] = 0;
      end else if (m_valid != 0) begin
        if (m_ph[s] >= clocks_per_bit(s) - 1) begin
          m_ph[s] = 0;
          m_idx[s] = (m_idx[s] >= frame_bits(s) - 1) ? 0 : m_idx[s] + 1;
        end else m_ph[s] = m_ph[s] + 1;
      end
    end
    if (m_valid == 0 && fs != 0) m_gci = m_fpq;
    if (fs != 0) m_valid = 1;
    if (changed != 0) begin
      m_seen = 1; m_run = 1;
    end else if (m_run < PMAX + 1) m_run = m_run + 1;
    m_fpq = int'(fp);
    m_primed = 1;
  endtask

  task automatic step(input logic f, input logic r, input logic c,
                      input logic [1:0] i, input logic [1:0] o);
    @(negedge clk);
    compare();
    fp = f; rst_n = r; cm = c; ir = i; orr = o;
    mstep();
  endtask

  task automatic tick(input logic f, input int n);
    for (int k = 0; k < n; k++) step(f, rst_n, cm, ir, orr);
  endtask

  task automatic cfg(input logic c, input logic [1:0] i, input logic [1:0] o);
    step(fp, rst_n, c, i, o);
  endtask

  task automatic window(input int n, output int nb, output int ns, output int nt);
    nb = 0; ns = 0; nt = 0;
    for (int k = 0; k < n; k++) begin
      tick(fp, 1);
      nb += int'(in_bnd_o); ns += int'(in_smp_o); nt += int'(out_tx_o);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int nb, ns, nt;
    mstep();
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b0, 2'd0, 2'd0);
    chk("R1", "reset valid", int'(fmt_valid_o), 0);
    chk("R1", "reset gci", int'(fmt_gci_o), 0);
    chk("R1", "reset in_chan", int'(in_chan_o), 0);
    step(1'b1, 1'b1, 1'b0, 2'd0, 2'd0);
    tick(1'b1, 10);
    // R2: low departure of 6 samples is too long
    tick(1'b0, 6);
    tick(1'b1, 10);
    chk("R2", "valid after wide departure", int'(fmt_valid_o), 0);
    chk("R1", "strobes quiet before lock", int'(in_bnd_o | out_tx_o), 0);
    // R1: one-sample low pulse locks active-low format
    tick(1'b0, 1);
    tick(1'b1, 2);
    chk("R1", "valid after pulse", int'(fmt_valid_o), 1);
    chk("R1", "gci after low pulse", int'(fmt_gci_o), 0);
    chk("R9", "tx_fall low format", int'(tx_fall_o), 1);
    chk("R4", "in_chan at frame start", int'(in_chan_o), 0);
    chk("R4", "in_bnd at frame start", int'(in_bnd_o), 1);
    // R5: equal rates, two clocks per bit
    window(16, nb, ns, nt);
    chk("R5", "bnd count 2x", nb, 8);
    chk("R5", "smp count 2x", ns, 8);
    tick(1'b1, 600);
    // R3: long low then short high pulse must not relock
    tick(1'b0, 10);
    tick(1'b1, 2);
    tick(1'b0, 10);
    chk("R3", "gci stays after opposite pulse", int'(fmt_gci_o), 0);
    chk("R3", "valid stays", int'(fmt_valid_o), 1);
    tick(1'b1, 20);
    // R6: equal rates at one clock per bit
    cfg(1'b1, 2'd1, 2'd1);
    tick(1'b0, 1);
    tick(1'b1, 3);
    window(8, nb, ns, nt);
    chk("R6", "bnd count 1x", nb, 8);
    chk("R6", "smp count 1x", ns, 8);
    tick(1'b1, 520);
    cfg(1'b1, 2'd2, 2'd2);
    tick(1'b1, 1030);
    // R8: code 3 acts as code 2
    cfg(1'b0, 2'd3, 2'd2);
    tick(1'b0, 1);
    tick(1'b1, 2100);
    // R7: unequal rates with both clock-mode values
    cfg(1'b1, 2'd0, 2'd2);
    tick(1'b0, 1);
    tick(1'b1, 3);
    window(16, nb, ns, nt);
    chk("R7", "slow side bnd cm1", nb, 4);
    chk("R7", "slow side smp cm1", ns, 4);
    chk("R7", "fast side tx cm1", nt, 16);
    cfg(1'b0, 2'd0, 2'd2);
    tick(1'b0, 1);
    tick(1'b1, 3);
    window(16, nb, ns, nt);
    chk("R7", "slow side bnd cm0", nb, 4);
    chk("R7", "slow side smp cm0", ns, 4);
    chk("R7", "fast side tx cm0", nt, 16);
    tick(1'b1, 300);
    cfg(1'b0, 2'd2, 2'd1);
    tick(1'b1, 300);
    // second reset, active-high format
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 1'b0, 2'd0, 2'd0);
    step(1'b0, 1'b1, 1'b0, 2'd0, 2'd0);
    tick(1'b0, 12);
    tick(1'b1, 2);
    tick(1'b0, 2);
    chk("R1", "gci after high pulse", int'(fmt_gci_o), 1);
    chk("R9", "smp_fall high format", int'(smp_fall_o), 1);
    chk("R9", "tx_fall high format", int'(tx_fall_o), 0);
    tick(1'b0, 100);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule